// File: doc/BRIEF.md
# Parallel-Load Shift Register with J/K First-Stage Entry

This block is a small register of `W` stages (four by default) that either captures a whole word at once or moves its contents one place toward the last stage. Stage 0 is the first stage and stage `W-1` is the last. A single mode input picks the operation for each rising clock edge. When the input is low, the register captures the parallel word. When it is high, the register shifts.

When shifting, the first stage does not take a plain serial bit. It is fed by a J input and an active-low K input, so it can hold, clear, set or toggle its own value. Wiring the two inputs together turns the first stage into a D flip-flop. An active-low clear empties the register at once, with no clock needed, and it beats every other input. The outputs are all stage values plus the inverse of the last stage. This lets a following stage use either polarity without an extra gate.

Top module: `pload_shreg`

## Requirements
- R1: While `clr_n` is low, every bit of `q` is 0 and `q_last_n` is 1. This takes effect at once, without a clock edge, and it overrides `shift_en`, `par_d`, `j_in` and `k_n_in`.
- R2: With `clr_n` high and `shift_en` low, a rising clock edge copies `par_d[i]` into `q[i]` for every stage i.
- R3: During a parallel load (`shift_en` low), `j_in` and `k_n_in` have no effect on any stage.
- R4: With `clr_n` high and `shift_en` high, a rising edge gives each stage i ≥ 1 the value that stage i-1 held before that edge.
- R5: In shift mode, the new `q[0]` depends on the pair {`j_in`,`k_n_in`} as follows:
  - 2'b01 keeps `q[0]`.
  - 2'b00 makes it 0.
  - 2'b11 makes it 1.
  - 2'b10 inverts it.
- R6: In shift mode with `j_in` equal to `k_n_in`, the new `q[0]` equals `j_in`, so the first stage acts as a D flip-flop.
- R7: `q_last_n` is always the inverse of `q[W-1]`.
- R8: With `clr_n` high, changes on `shift_en`, `par_d`, `j_in` or `k_n_in` between rising edges leave `q` unchanged. The state moves only on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates except clear happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| j_in | input | 1 | J input for first-stage entry |
| k_n_in | input | 1 | Active-low K input for first-stage entry |
| par_d | input | W | Parallel data; bit i goes to stage i |
| q | output | W | Stage values; bit 0 is the first stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The checker runs on every clock edge. It checks that an active clear leaves the register empty, that a load copies the parallel word, that a shift moves each stage up by one place, and that the first stage follows the J/K rule. The bench's scenarios cover the rest. They show that clear acts mid-cycle before any edge arrives, and that input changes between edges leave the stages alone. They also run the D-style tied-input case, long toggle runs, and the complement output. A scoreboard compares the stages and the complement output against a reference model after every edge of a long random mix of clear, load and shift operations.

// File: rtl/shreg_pkg.sv
// Package: shared types for the parallel-load shift register.
// Assumes the first-stage entry code is formed as {j, k_n}.
package shreg_pkg;

    // First-stage entry behaviour, encoded as {j_in, k_n_in}
    typedef enum logic [1:0] {
        ENTRY_CLR  = 2'b00,
        ENTRY_HOLD = 2'b01,
        ENTRY_TGL  = 2'b10,
        ENTRY_SET  = 2'b11
    } entry_mode_e;

endpackage

// File: rtl/shreg_entry.sv
// Module: shreg_entry
// Works out the next value of the first stage in shift mode from the
// J / active-low K pair and the stage's present value.
// Assumes: the caller picks between this result and parallel data.
module shreg_entry
    import shreg_pkg::*;
(
    input  logic j_in,
    input  logic k_n_in,
    input  logic cur,
    output logic nxt
);

    entry_mode_e mode;

    // Form the entry mode code from the two serial inputs
    always_comb mode = entry_mode_e'({j_in, k_n_in});

    // Choose the first-stage next value for the selected mode
    always_comb begin
        unique case (mode)
            ENTRY_CLR:  nxt = 1'b0;
            ENTRY_HOLD: nxt = cur;
            ENTRY_TGL:  nxt = ~cur;
            ENTRY_SET:  nxt = 1'b1;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/shreg_next.sv
// Module: shreg_next
// Per-stage next-state select: parallel word when loading, or the
// previous stage (entry bit for stage 0) when shifting.
// Assumes: W >= 2.
module shreg_next #(
    parameter int W = 4
) (
    input  logic         shift_en,
    input  logic         entry_bit,
    input  logic [W-1:0] par_d,
    input  logic [W-1:0] cur_q,
    output logic [W-1:0] nxt_q
);

    for (genvar i = 0; i < W; i++) begin : g_sel
        if (i == 0) begin : g_head
            // First stage: entry logic when shifting, parallel bit when loading
            always_comb nxt_q[i] = shift_en ? entry_bit : par_d[i];
        end else begin : g_body
            // Later stages: previous stage when shifting, parallel bit when loading
            always_comb nxt_q[i] = shift_en ? cur_q[i-1] : par_d[i];
        end
    end

endmodule

// File: rtl/shreg_store.sv
// Module: shreg_store
// Bank of W rising-edge flops with a shared asynchronous active-low clear.
// Assumes: clr_n is released away from a clock edge by the system.
module shreg_store #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_ff
        // One stage: clear at once, otherwise capture on the rising edge
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
        end
    end

endmodule

// File: rtl/pload_shreg.sv
// Module: pload_shreg (top)
// W-stage register with parallel load, shift toward the last stage,
// J / active-low K entry into the first stage, asynchronous clear and
// an inverted copy of the last stage.
// Assumes: W >= 2; no clear synchroniser is provided here.
module pload_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         shift_en,
    input  logic         j_in,
    input  logic         k_n_in,
    input  logic [W-1:0] par_d,
    output logic [W-1:0] q,
    output logic         q_last_n
);

    localparam int LAST = W - 1;

    logic         entry_bit;
    logic [W-1:0] nxt_q;

    shreg_entry u_entry (
        .j_in   (j_in),
        .k_n_in (k_n_in),
        .cur    (q[0]),
        .nxt    (entry_bit)
    );

    shreg_next #(.W(W)) u_next (
        .shift_en  (shift_en),
        .entry_bit (entry_bit),
        .par_d     (par_d),
        .cur_q     (q),
        .nxt_q     (nxt_q)
    );

    shreg_store #(.W(W)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (nxt_q),
        .q     (q)
    );

    // Drive the complemented last-stage output
    always_comb q_last_n = ~q[LAST];

endmodule

// File: rtl/shreg_chk.sv
// Module: shreg_chk
// Clocked property checker for pload_shreg, attached by bind below.
// Assumes: clear spans at least one rising edge when asserted by the system.
module shreg_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         shift_en,
    input logic         j_in,
    input logic         k_n_in,
    input logic [W-1:0] par_d,
    input logic [W-1:0] q,
    input logic         q_last_n
);

    AST_CLEAR_EMPTY: assert property (@(posedge clk) !clr_n |-> (q == '0 && q_last_n)) // R1
        else $error("clear did not empty register");

    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!clr_n)
        !shift_en |=> q == $past(par_d)) // R2
        else $error("load mismatch");

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!clr_n)
        shift_en |=> q[W-1:1] == $past(q[W-2:0])) // R4
        else $error("shift mismatch");

    AST_ENTRY_JK: assert property (@(posedge clk) disable iff (!clr_n)
        shift_en |=> q[0] == (($past(j_in) & ~$past(q[0])) | ($past(k_n_in) & $past(q[0])))) // R5
        else $error("first-stage entry mismatch");

endmodule

bind pload_shreg shreg_chk #(.W(W)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .j_in     (j_in),
    .k_n_in   (k_n_in),
    .par_d    (par_d),
    .q        (q),
    .q_last_n (q_last_n)
);

// File: tb/tb_pload_shreg.sv
// Scoreboard bench: driver tasks push expected words, a monitor pops them
// after each rising edge and compares the stages and the complement output.
module tb_pload_shreg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         shift_en = 1'b0;
    logic         j_in = 1'b0;
    logic         k_n_in = 1'b1;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] model = '0;
    logic [W-1:0] exp_q[$];
    string        exp_r[$];

    pload_shreg #(.W(W)) dut (
        .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .j_in(j_in),
        .k_n_in(k_n_in), .par_d(par_d), .q(q), .q_last_n(q_last_n)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare each produced result against the queued expectation
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = exp_r.pop_front();
            check(r, q, e);
            check("R7", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~e[W-1]});
        end
    end

    // Driver: one operation for the next rising edge (clear released here)
    task automatic step(input logic se, input logic j, input logic kn,
                        input logic [W-1:0] d, input string req);
        logic e0;
        @(negedge clk);
        clr_n = 1'b1; shift_en = se; j_in = j; k_n_in = kn; par_d = d;
        if (se) begin
            e0 = (j & ~model[0]) | (kn & model[0]);
            model = {model[W-2:0], e0};
        end else begin
            model = d;
        end
        exp_q.push_back(model);
        exp_r.push_back(req);
    endtask

    // Driver: clear mid-cycle, check at once, and hold through the next edge
    task automatic do_clear();
        @(negedge clk);
        shift_en = 1'b0; par_d = '1; j_in = 1'b1; k_n_in = 1'b1;
        #3 clr_n = 1'b0;
        #2;
        check("R1", q, '0);   // R1: no edge needed
        check("R1", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
        model = '0;
        exp_q.push_back(model);
        exp_r.push_back("R1");
    endtask

    // Driver: inputs wander between edges; state must not move (R8)
    task automatic wander_step(input logic [W-1:0] d);
        logic [W-1:0] snap;
        step(1'b0, 1'b0, 1'b1, d, "R2");
        #2 snap = q;
        shift_en = 1'b1; j_in = 1'b1; k_n_in = 1'b0; par_d = ~d;
        #3 check("R8", q, snap);
        shift_en = 1'b0; j_in = 1'b0; k_n_in = 1'b1; par_d = d;
        #2 check("R8", q, snap);
    endtask

    initial begin
        do_clear();
        step(1'b0, 1'b1, 1'b0, 4'b1010, "R2");      // R3: J/K would toggle, ignored
        step(1'b0, 1'b1, 1'b1, 4'b0101, "R3");
        step(1'b1, 1'b0, 1'b1, '0, "R5");           // hold
        step(1'b1, 1'b1, 1'b1, '0, "R5");           // set
        step(1'b1, 1'b0, 1'b0, '0, "R4");           // clear entry, shift
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, '0, "R5");   // toggle run
        for (int i = 0; i < 8; i++) begin
            logic b;
            b = logic'((i * 5 + 1) % 3 == 0);
            step(1'b1, b, b, '0, "R6");             // tied inputs act as D
        end
        wander_step(4'b0110);
        do_clear();
        step(1'b1, 1'b1, 1'b1, '0, "R4");
        for (int i = 0; i < 200; i++) begin
            int op;
            logic j, kn;
            op = $urandom_range(0, 9);
            j = 1'($urandom_range(0, 1));
            kn = 1'($urandom_range(0, 1));
            if (op == 0)      do_clear();
            else if (op < 4)  step(1'b0, j, kn, W'($urandom_range(0, 15)), "R2");
            else if (j == kn) step(1'b1, j, kn, W'($urandom_range(0, 15)), "R6");
            else              step(1'b1, j, kn, W'($urandom_range(0, 15)), "R5");
        end
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule